// File: doc/BRIEF.md
# Configurable Serial Receive Engine

This block turns an asynchronous serial input into bytes. The baud rate comes from an integer clock divisor: one bit lasts exactly `divisor` clock cycles. Each frame has a start bit, 5 to 8 data bits sent least significant bit first, an optional even or odd parity bit, and 1, 1.5 or 2 stop bits. After the last stop sample, the block either writes the byte to an external FIFO write port or reports why it could not. The possible reports are a parity error, a stop-bit (frame) error, a line break, or an overflow because the FIFO was full.

The same engine watches the line between frames. When the idle-timeout function is enabled, it raises a one-cycle timeout event after the line has been quiet for a set number of byte times while the FIFO still holds data. It also generates an active-low ready-to-send output from the FIFO fill count, which it receives as an input. The input line can be inverted before any processing. The FIFO storage, the transmitter and any register access are outside this block. All configuration arrives on plain input ports.

Top module: `uart_rx_engine`

## Requirements
- R1: Once a start bit is confirmed, each data bit is sampled `divisor` cycles after the previous sample, near the centre of the bit. Data bits arrive least significant bit first. A frame with a good stop bit and no errors produces exactly one `pushValid` pulse, with the received byte on `pushData`.
- R2: `dataLenSel` selects 5 + `dataLenSel` data bits (0 = 5, 1 = 6, 2 = 7, 3 = 8). The received bits are right-aligned on `pushData`, and every bit above the selected length is zero.
- R3: With `parityOn` set, one parity bit follows the data. `parityOdd` = 0 expects an even number of ones across data and parity, and 1 expects an odd number. A mismatch pulses `parityErr` in the same cycle as the push, and the byte is still pushed.
- R4: `stopSel` values 2 and 3 select 1.5 and 2 stop bits, and any other value selects 1. The first stop bit is sampled at its centre. With 1.5 stop bits a second sample follows 3/4 of a bit later; with 2 stop bits it follows one full bit later. Any low stop sample pulses `frameErr`, and the byte is still pushed.
- R5: A frame whose data, parity and stop samples are all low pulses `breakDet` only. It pushes nothing and raises no frame or parity error. A line that stays low afterwards starts no new frame.
- R6: A falling edge starts a candidate start bit, which is checked once, half a bit period later. If the line is high at that check, the candidate is discarded, and nothing is pushed or flagged.
- R7: If `fifoFull` is high when a valid byte completes, the byte is not pushed and `overflow` pulses for one cycle instead.
- R8: When `invertRx` is high, the input line is inverted before synchronisation, so an inverted serial stream decodes to the same bytes.
- R9: With `idleEn` set and the engine idle, an idle count advances by one byte time for every 10 bit periods without a start edge, saturating at its maximum. `idleTimeout` pulses once when the count is at least `idleThresh` and `fifoCount` is non-zero. It never fires while `fifoCount` is zero, and it fires again only after a new start edge.
- R10: `rtsN` is registered and equals `flowEn && fifoCount > flowThresh`, so it goes high (deasserted) only when the count is strictly greater than the threshold. It resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxLine | input | 1 | Serial input line |
| invertRx | input | 1 | Invert the input line before processing |
| divisor | input | 20 | Clock cycles per bit (values below 4 are treated as 4) |
| dataLenSel | input | 2 | Data length select, 5 + value bits |
| stopSel | input | 2 | Stop-bit select: 2 = 1.5 bits, 3 = 2 bits, else 1 bit |
| parityOn | input | 1 | Expect and check a parity bit |
| parityOdd | input | 1 | 0 = even parity, 1 = odd parity |
| idleEn | input | 1 | Enable the idle timeout event |
| idleThresh | input | 7 | Idle byte times before a timeout |
| flowEn | input | 1 | Enable ready-to-send generation |
| flowThresh | input | 7 | Fill count above which `rtsN` goes high |
| fifoCount | input | 8 | Current fill count of the receive FIFO |
| fifoFull | input | 1 | Receive FIFO cannot take a byte |
| pushValid | output | 1 | One-cycle write strobe to the FIFO |
| pushData | output | 8 | Received byte, right-aligned |
| parityErr | output | 1 | Parity mismatch pulse |
| frameErr | output | 1 | Low stop-bit pulse |
| breakDet | output | 1 | All-low frame pulse |
| overflow | output | 1 | Byte dropped because the FIFO was full |
| idleTimeout | output | 1 | Idle timeout event pulse |
| rtsN | output | 1 | Active-low ready-to-send |

## Verification
The assertions assume that `dataLenSel`, `fifoFull` and the flow-control inputs only change while no frame is in flight. This is because the width check on `pushData` and the push-versus-full check compare an output with the input value from the cycle before. The stimulus changes the frame format, the inversion and the FIFO status only while the line is idle, and leaves several bit periods before the next start bit. It also flips the bench-side inversion and `invertRx` on the same edge, so the logical line never glitches.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP1,
    ST_STOP2
  } rxState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadHalf;
    logic loadThreeQ;
    logic clearFrame;
    logic sampleData;
    logic samplePar;
    logic sampleStop;
    logic frameDone;
    logic countIdle;
  } ctlStrobes_t;

endpackage

// File: rtl/uart_rx_control.sv
module uart_rx_control
  import uart_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startEdge,
  input  logic        baudTick,
  input  logic        lineNow,
  input  logic        lastData,
  input  logic        parityOn,
  input  logic [1:0]  stopSel,
  output ctlStrobes_t stb
);

  rxState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb           = '0;
    nextState     = state;
    stb.countIdle = (state == ST_IDLE);
    case (state)
      ST_IDLE: if (startEdge) begin
        stb.loadHalf   = 1'b1;
        stb.clearFrame = 1'b1;
        nextState      = ST_START;
      end
      ST_START: if (baudTick) begin
        nextState = lineNow ? ST_IDLE : ST_DATA;
      end
      ST_DATA: if (baudTick) begin
        stb.sampleData = 1'b1;
        if (lastData) nextState = parityOn ? ST_PARITY : ST_STOP1;
      end
      ST_PARITY: if (baudTick) begin
        stb.samplePar = 1'b1;
        nextState     = ST_STOP1;
      end
      ST_STOP1: if (baudTick) begin
        stb.sampleStop = 1'b1;
        case (stopSel)
          2'd2: begin
            stb.loadThreeQ = 1'b1;
            nextState      = ST_STOP2;
          end
          2'd3: nextState = ST_STOP2;
          default: begin
            stb.frameDone = 1'b1;
            nextState     = ST_IDLE;
          end
        endcase
      end
      ST_STOP2: if (baudTick) begin
        stb.sampleStop = 1'b1;
        stb.frameDone  = 1'b1;
        nextState      = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/uart_rx_datapath.sv
module uart_rx_datapath
  import uart_rx_pkg::*;
#(
  parameter int DIV_W         = 20,
  parameter int DATA_W        = 8,
  parameter int THR_W         = 7,
  parameter int CNT_W         = 8,
  parameter int BITS_PER_BYTE = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              invertRx,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [1:0]        dataLenSel,
  input  logic              parityOn,
  input  logic              parityOdd,
  input  logic              idleEn,
  input  logic [THR_W-1:0]  idleThresh,
  input  logic              flowEn,
  input  logic [THR_W-1:0]  flowThresh,
  input  logic [CNT_W-1:0]  fifoCount,
  input  logic              fifoFull,
  input  ctlStrobes_t       stb,
  output logic              lineNow,
  output logic              startEdge,
  output logic              baudTick,
  output logic              lastData,
  output logic              pushValid,
  output logic [DATA_W-1:0] pushData,
  output logic              parityErr,
  output logic              frameErr,
  output logic              breakDet,
  output logic              overflow,
  output logic              idleTimeout,
  output logic              rtsN
);

  localparam int IDX_W   = $clog2(DATA_W);
  localparam int MIN_LEN = DATA_W - 3;
  localparam int IBIT_W  = $clog2(BITS_PER_BYTE);
  localparam logic [DIV_W-1:0] DIV_FLOOR = DIV_W'(4);

  // input synchroniser and edge detect
  logic [1:0] syncQ;
  logic       prevLine;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= 2'b11;
      prevLine <= 1'b1;
    end else begin
      syncQ    <= {syncQ[0], rxLine ^ invertRx};
      prevLine <= syncQ[1];
    end
  end
  assign lineNow   = syncQ[1];
  assign startEdge = prevLine & ~syncQ[1];

  // bit timer, free-running between frames so it also paces the idle count
  logic [DIV_W-1:0] effDiv, baudCnt;
  assign effDiv   = (divisor < DIV_FLOOR) ? DIV_FLOOR : divisor;
  assign baudTick = (baudCnt == '0);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               baudCnt <= '0;
    else if (stb.loadHalf)   baudCnt <= (effDiv >> 1) - 1'b1;
    else if (stb.loadThreeQ) baudCnt <= (effDiv >> 1) + (effDiv >> 2) - 1'b1;
    else if (baudTick)       baudCnt <= effDiv - 1'b1;
    else                     baudCnt <= baudCnt - 1'b1;
  end

  // frame accumulation
  logic [DATA_W-1:0] shiftReg;
  logic [IDX_W-1:0]  bitIdx;
  logic              parAcc, anyHigh, stopOk;
  assign lastData = (bitIdx == IDX_W'(MIN_LEN - 1) + IDX_W'(dataLenSel));
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitIdx   <= '0;
      parAcc   <= 1'b0;
      anyHigh  <= 1'b0;
      stopOk   <= 1'b1;
    end else if (stb.clearFrame) begin
      shiftReg <= '0;
      bitIdx   <= '0;
      parAcc   <= 1'b0;
      anyHigh  <= 1'b0;
      stopOk   <= 1'b1;
    end else begin
      if (stb.sampleData) begin
        shiftReg <= {lineNow, shiftReg[DATA_W-1:1]};
        bitIdx   <= bitIdx + 1'b1;
      end
      if (stb.sampleData || stb.samplePar) parAcc <= parAcc ^ lineNow;
      if (stb.sampleData || stb.samplePar || stb.sampleStop) anyHigh <= anyHigh | lineNow;
      if (stb.sampleStop) stopOk <= stopOk & lineNow;
    end
  end

  // frame verdict (final stop sample coincides with frameDone)
  logic             finalAny, finalStop;
  logic [IDX_W-1:0] alignShift;
  assign finalAny   = anyHigh | lineNow;
  assign finalStop  = stopOk & lineNow;
  assign alignShift = IDX_W'(DATA_W - MIN_LEN) - IDX_W'(dataLenSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pushValid <= 1'b0;
      pushData  <= '0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
      breakDet  <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      pushValid <= stb.frameDone & finalAny & ~fifoFull;
      overflow  <= stb.frameDone & finalAny & fifoFull;
      breakDet  <= stb.frameDone & ~finalAny;
      frameErr  <= stb.frameDone & finalAny & ~finalStop;
      parityErr <= stb.frameDone & finalAny & parityOn & (parAcc != parityOdd);
      if (stb.frameDone && finalAny && !fifoFull) pushData <= shiftReg >> alignShift;
    end
  end

  // idle timeout counting in byte times
  logic [IBIT_W-1:0] idleBits;
  logic [THR_W-1:0]  idleBytes;
  logic              fired, fireNow;
  assign fireNow = idleEn & stb.countIdle & ~fired & (idleBytes >= idleThresh)
                 & (fifoCount != '0);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleBits    <= '0;
      idleBytes   <= '0;
      fired       <= 1'b0;
      idleTimeout <= 1'b0;
    end else begin
      idleTimeout <= fireNow;
      if (stb.clearFrame)  fired <= 1'b0;
      else if (fireNow)    fired <= 1'b1;
      if (stb.clearFrame || stb.frameDone) begin
        idleBits  <= '0;
        idleBytes <= '0;
      end else if (stb.countIdle && baudTick) begin
        if (idleBits == IBIT_W'(BITS_PER_BYTE - 1)) begin
          idleBits <= '0;
          if (idleBytes != '1) idleBytes <= idleBytes + 1'b1;
        end else begin
          idleBits <= idleBits + 1'b1;
        end
      end
    end
  end

  // ready-to-send from the FIFO fill level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rtsN <= 1'b0;
    else       rtsN <= flowEn & (fifoCount > CNT_W'(flowThresh));
  end

endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
  import uart_rx_pkg::*;
#(
  parameter int DIV_W         = 20,
  parameter int DATA_W        = 8,
  parameter int THR_W         = 7,
  parameter int CNT_W         = 8,
  parameter int BITS_PER_BYTE = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              invertRx,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [1:0]        dataLenSel,
  input  logic [1:0]        stopSel,
  input  logic              parityOn,
  input  logic              parityOdd,
  input  logic              idleEn,
  input  logic [THR_W-1:0]  idleThresh,
  input  logic              flowEn,
  input  logic [THR_W-1:0]  flowThresh,
  input  logic [CNT_W-1:0]  fifoCount,
  input  logic              fifoFull,
  output logic              pushValid,
  output logic [DATA_W-1:0] pushData,
  output logic              parityErr,
  output logic              frameErr,
  output logic              breakDet,
  output logic              overflow,
  output logic              idleTimeout,
  output logic              rtsN
);

  ctlStrobes_t stb;
  logic        lineNow, startEdge, baudTick, lastData;

  uart_rx_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .startEdge (startEdge),
    .baudTick  (baudTick),
    .lineNow   (lineNow),
    .lastData  (lastData),
    .parityOn  (parityOn),
    .stopSel   (stopSel),
    .stb       (stb)
  );

  uart_rx_datapath #(
    .DIV_W         (DIV_W),
    .DATA_W        (DATA_W),
    .THR_W         (THR_W),
    .CNT_W         (CNT_W),
    .BITS_PER_BYTE (BITS_PER_BYTE)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .rxLine      (rxLine),
    .invertRx    (invertRx),
    .divisor     (divisor),
    .dataLenSel  (dataLenSel),
    .parityOn    (parityOn),
    .parityOdd   (parityOdd),
    .idleEn      (idleEn),
    .idleThresh  (idleThresh),
    .flowEn      (flowEn),
    .flowThresh  (flowThresh),
    .fifoCount   (fifoCount),
    .fifoFull    (fifoFull),
    .stb         (stb),
    .lineNow     (lineNow),
    .startEdge   (startEdge),
    .baudTick    (baudTick),
    .lastData    (lastData),
    .pushValid   (pushValid),
    .pushData    (pushData),
    .parityErr   (parityErr),
    .frameErr    (frameErr),
    .breakDet    (breakDet),
    .overflow    (overflow),
    .idleTimeout (idleTimeout),
    .rtsN        (rtsN)
  );

endmodule

// File: rtl/uart_rx_checks.sv
module uart_rx_checks #(
  parameter int DATA_W = 8,
  parameter int THR_W  = 7,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        dataLenSel,
  input logic              idleEn,
  input logic              flowEn,
  input logic [THR_W-1:0]  flowThresh,
  input logic [CNT_W-1:0]  fifoCount,
  input logic              fifoFull,
  input logic              pushValid,
  input logic [DATA_W-1:0] pushData,
  input logic              parityErr,
  input logic              frameErr,
  input logic              breakDet,
  input logic              overflow,
  input logic              idleTimeout,
  input logic              rtsN
);

  logic primed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  // R1: a push strobe lasts one cycle
  a_r1_push_single: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |=> !pushValid) else $error("push strobe held");

  // R2: bits above the selected length are zero
  a_r2_push_width: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |-> ((32'(pushData) >> (5 + 32'(dataLenSel))) == 0))
    else $error("pushData wider than selected length");

  // R5: break excludes push and other errors
  a_r5_break_alone: assert property (@(posedge clk) disable iff (!rstN)
    breakDet |-> (!pushValid && !frameErr && !parityErr))
    else $error("break with other events");

  // R7: no push into a full FIFO, overflow replaces the push
  a_r7_no_push_full: assert property (@(posedge clk) disable iff (!rstN || !primed)
    pushValid |-> !$past(fifoFull)) else $error("push while full");
  a_r7_ovf_no_push: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> !pushValid) else $error("overflow with push");

  // R9: timeout needs data and enable, and is a single pulse
  a_r9_timeout_data: assert property (@(posedge clk) disable iff (!rstN || !primed)
    idleTimeout |-> ($past(fifoCount) != '0 && $past(idleEn)))
    else $error("timeout without data");
  a_r9_timeout_pulse: assert property (@(posedge clk) disable iff (!rstN)
    idleTimeout |=> !idleTimeout) else $error("timeout held");

  // R10: ready-to-send follows the fill level one cycle later
  a_r10_rts_level: assert property (@(posedge clk) disable iff (!rstN || !primed)
    rtsN == $past(flowEn && (fifoCount > CNT_W'(flowThresh))))
    else $error("rtsN mismatch");

endmodule

bind uart_rx_engine uart_rx_checks #(.DATA_W(DATA_W), .THR_W(THR_W), .CNT_W(CNT_W)) u_checks (
  .clk         (clk),
  .rstN        (rstN),
  .dataLenSel  (dataLenSel),
  .idleEn      (idleEn),
  .flowEn      (flowEn),
  .flowThresh  (flowThresh),
  .fifoCount   (fifoCount),
  .fifoFull    (fifoFull),
  .pushValid   (pushValid),
  .pushData    (pushData),
  .parityErr   (parityErr),
  .frameErr    (frameErr),
  .breakDet    (breakDet),
  .overflow    (overflow),
  .idleTimeout (idleTimeout),
  .rtsN        (rtsN)
);

// File: tb/uart_rx_engine_bench.sv
`timescale 1ns/1ps
module uart_rx_engine_bench;

  localparam int DIV = 16;
  localparam int TO_THR = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lineLevel = 1'b1;
  logic        invBench = 1'b0;
  logic        rxLine;
  logic        invertRx = 1'b0;
  logic [19:0] divisor = 20'(DIV);
  logic [1:0]  dataLenSel = 2'd3;
  logic [1:0]  stopSel = 2'd1;
  logic        parityOn = 1'b0, parityOdd = 1'b0;
  logic        idleEn = 1'b0;
  logic [6:0]  idleThresh = 7'(TO_THR);
  logic        flowEn = 1'b0;
  logic [6:0]  flowThresh = 7'd0;
  logic [7:0]  fifoCount = 8'd0;
  logic        fifoFull = 1'b0;
  logic        pushValid, parityErr, frameErr, breakDet, overflow, idleTimeout, rtsN;
  logic [7:0]  pushData;

  assign rxLine = lineLevel ^ invBench;

  always #10 clk = ~clk;

  uart_rx_engine u_uart_rx_engine (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .invertRx(invertRx), .divisor(divisor),
    .dataLenSel(dataLenSel), .stopSel(stopSel), .parityOn(parityOn), .parityOdd(parityOdd),
    .idleEn(idleEn), .idleThresh(idleThresh), .flowEn(flowEn), .flowThresh(flowThresh),
    .fifoCount(fifoCount), .fifoFull(fifoFull), .pushValid(pushValid), .pushData(pushData),
    .parityErr(parityErr), .frameErr(frameErr), .breakDet(breakDet), .overflow(overflow),
    .idleTimeout(idleTimeout), .rtsN(rtsN)
  );

  int nChecks = 0, nBad = 0;
  int nPush = 0, nPar = 0, nFrm = 0, nBrk = 0, nOvf = 0, nTo = 0;
  logic [7:0] lastData = 8'h00;
  bit finished = 1'b0;

  always @(negedge clk) if (rstN) begin
    if (pushValid)   begin nPush++; lastData = pushData; end
    if (parityErr)   nPar++;
    if (frameErr)    nFrm++;
    if (breakDet)    nBrk++;
    if (overflow)    nOvf++;
    if (idleTimeout) nTo++;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clearCounts();
    nPush = 0; nPar = 0; nFrm = 0; nBrk = 0; nOvf = 0; nTo = 0; lastData = 8'h00;
  endtask

  task automatic driveFor(input logic lvl, input int cycles);
    lineLevel = lvl;
    repeat (cycles) @(negedge clk);
  endtask

  // start, data LSB first, optional parity, one stop, then idle
  task automatic sendFrame(input logic [7:0] d, input int len, input int parBit, input logic stopLvl);
    driveFor(1'b0, DIV);
    for (int i = 0; i < len; i++) driveFor(d[i], DIV);
    if (parBit >= 0) driveFor(parBit[0], DIV);
    driveFor(stopLvl, DIV);
    driveFor(1'b1, 3 * DIV);
  endtask

  task automatic checkClean(input string req, input int pushes, input int data);
    check(req, "push count", nPush, pushes);
    if (pushes > 0) check(req, "data", int'(lastData), data);
    check(req, "parity errors", nPar, 0);
    check(req, "frame errors", nFrm, 0);
    check(req, "breaks", nBrk, 0);
  endtask

  task automatic t_reset();
    check("R10", "rtsN after reset", int'(rtsN), 0);
    check("R1", "pushValid after reset", int'(pushValid), 0);
    check("R9", "timeout after reset", nTo, 0);
  endtask

  task automatic t_basic();
    clearCounts(); sendFrame(8'hA5, 8, -1, 1'b1); checkClean("R1", 1, 8'hA5);
    clearCounts(); sendFrame(8'h3C, 8, -1, 1'b1); checkClean("R1", 1, 8'h3C);
  endtask

  task automatic t_length();
    dataLenSel = 2'd0; clearCounts(); sendFrame(8'hF5, 5, -1, 1'b1); checkClean("R2", 1, 8'h15);
    dataLenSel = 2'd1; clearCounts(); sendFrame(8'hEB, 6, -1, 1'b1); checkClean("R2", 1, 8'h2B);
    dataLenSel = 2'd2; clearCounts(); sendFrame(8'hDA, 7, -1, 1'b1); checkClean("R2", 1, 8'h5A);
    dataLenSel = 2'd3;
  endtask

  task automatic t_parity();
    parityOn = 1'b1; parityOdd = 1'b0;
    clearCounts(); sendFrame(8'hA5, 8, 0, 1'b1); checkClean("R3", 1, 8'hA5);
    clearCounts(); sendFrame(8'h07, 8, 0, 1'b1);
    check("R3", "even parity error", nPar, 1);
    check("R3", "push despite parity error", nPush, 1);
    parityOdd = 1'b1;
    clearCounts(); sendFrame(8'hA5, 8, 1, 1'b1); checkClean("R3", 1, 8'hA5);
    parityOn = 1'b0; parityOdd = 1'b0;
  endtask

  task automatic t_stop();
    clearCounts(); sendFrame(8'h81, 8, -1, 1'b0);
    check("R4", "one stop low frame error", nFrm, 1);
    check("R4", "push despite frame error", nPush, 1);
    stopSel = 2'd2; clearCounts();
    driveFor(1'b0, DIV);
    for (int i = 0; i < 8; i++) driveFor(logic'((8'h42 >> i) & 1), DIV);
    driveFor(1'b1, DIV); driveFor(1'b0, DIV / 2); driveFor(1'b1, 3 * DIV);
    check("R4", "1.5 stop second half low", nFrm, 1);
    stopSel = 2'd3; clearCounts();
    driveFor(1'b0, DIV);
    for (int i = 0; i < 8; i++) driveFor(logic'((8'h42 >> i) & 1), DIV);
    driveFor(1'b1, DIV); driveFor(1'b0, DIV); driveFor(1'b1, 3 * DIV);
    check("R4", "2 stop second low", nFrm, 1);
    clearCounts(); sendFrame(8'h42, 8, -1, 1'b1); driveFor(1'b1, DIV);
    checkClean("R4", 1, 8'h42);
    stopSel = 2'd1;
  endtask

  task automatic t_break();
    clearCounts(); driveFor(1'b0, 12 * DIV); driveFor(1'b1, 3 * DIV);
    check("R5", "break pulses", nBrk, 1);
    check("R5", "no push on break", nPush, 0);
    check("R5", "no frame error on break", nFrm, 0);
  endtask

  task automatic t_glitch();
    clearCounts(); driveFor(1'b0, 3); driveFor(1'b1, 3 * DIV);
    check("R6", "glitch pushes", nPush, 0);
    check("R6", "glitch flags", nFrm + nBrk + nPar, 0);
    clearCounts(); sendFrame(8'h5A, 8, -1, 1'b1); checkClean("R6", 1, 8'h5A);
  endtask

  task automatic t_overflow();
    fifoFull = 1'b1; clearCounts(); sendFrame(8'h33, 8, -1, 1'b1);
    check("R7", "overflow pulses", nOvf, 1);
    check("R7", "no push when full", nPush, 0);
    fifoFull = 1'b0;
  endtask

  task automatic t_invert();
    invBench = 1'b1; invertRx = 1'b1; driveFor(1'b1, 4 * DIV);
    clearCounts(); sendFrame(8'hC3, 8, -1, 1'b1); checkClean("R8", 1, 8'hC3);
    invBench = 1'b0; invertRx = 1'b0; driveFor(1'b1, 4 * DIV);
  endtask

  task automatic t_timeout();
    fifoCount = 8'd0; idleEn = 1'b1; clearCounts();
    driveFor(1'b0, DIV);
    for (int i = 0; i < 8; i++) driveFor(logic'((8'h66 >> i) & 1), DIV);
    lineLevel = 1'b1; fifoCount = 8'd1;
    driveFor(1'b1, DIV);
    repeat (TO_THR * 10 * DIV - 2 * DIV) @(negedge clk);
    check("R9", "no timeout before threshold", nTo, 0);
    repeat (4 * DIV) @(negedge clk);
    check("R9", "timeout after threshold", nTo, 1);
    repeat (400) @(negedge clk);
    check("R9", "single timeout pulse", nTo, 1);
    fifoCount = 8'd0; clearCounts(); sendFrame(8'h11, 8, -1, 1'b1);
    repeat (600) @(negedge clk);
    check("R9", "no timeout with empty fifo", nTo, 0);
    fifoCount = 8'd1; repeat (4) @(negedge clk);
    check("R9", "timeout once data present", nTo, 1);
    idleEn = 1'b0; fifoCount = 8'd0;
  endtask

  task automatic t_rts();
    flowEn = 1'b1; flowThresh = 7'd20;
    fifoCount = 8'd20; repeat (3) @(negedge clk);
    check("R10", "rtsN at threshold", int'(rtsN), 0);
    fifoCount = 8'd21; repeat (3) @(negedge clk);
    check("R10", "rtsN above threshold", int'(rtsN), 1);
    flowEn = 1'b0; repeat (3) @(negedge clk);
    check("R10", "rtsN with flow off", int'(rtsN), 0);
    fifoCount = 8'd0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4 * DIV) @(negedge clk);
    t_reset();
    t_basic();
    t_length();
    t_parity();
    t_stop();
    t_break();
    t_glitch();
    t_overflow();
    t_invert();
    t_timeout();
    t_rts();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nBad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

endmodule